// File: doc/BRIEF.md
# Byte-Wide Register-File ALU Sequencer

This block is a small execution unit. It takes one 16-bit byte-oriented instruction word at a time and runs it over four fixed phases: decode, operand read, compute and write-back. Two operations are implemented. The first subtracts the working register and a borrow from a byte in banked data memory. The second exchanges the two nibbles of that byte. Every other instruction word passes through the same four phases and has no effect.

Each instruction picks where its result goes: the working register or the file byte it read. It also picks how the 12-bit data address is formed. In access mode a fixed split of the 8-bit file address is used: the low half maps to bank 0 and the high half maps to bank 15. In banked mode the 4-bit bank select input becomes the upper address bits. A surrounding core loads the word and pulses `start`. It then waits while `busy` is high and reads the updated working register and status flags afterwards.

Top module: `regalu_seq`

## Requirements
- R1: Instruction fields are op = instr[15:10], dest = instr[9], bank mode = instr[8] and file address f = instr[7:0]. Op 6'b010110 selects subtract-with-borrow. Op 6'b001110 selects nibble swap.
- R2: When `start` is seen while idle, the instruction word and the bank select value are captured and `busy` stays high for exactly four cycles. A `start` that arrives while `busy` is high is ignored.
- R3: `mem_rd` is high only in the second phase of a valid operation. In that phase `mem_addr` is {bank_sel, f} when the bank-mode bit is 1. When the bit is 0, `mem_addr` is {4'h0, f} for f below 0x80 and {4'hF, f} otherwise, and bank_sel is ignored.
- R4: Subtract-with-borrow gives f − W − borrow, modulo 256, where borrow is the inverse of the current carry flag.
- R5: The status layout is status[0]=C, [1]=DC, [2]=Z, [3]=OV, [4]=N. After a subtraction, C=1 means no borrow out of bit 7 and DC=1 means no borrow out of bit 3. Z is set when the result is zero and N copies result bit 7. OV is set when f and W differ in sign and the result's sign differs from f's.
- R6: Nibble swap gives {f[3:0], f[7:4]} and leaves every status bit unchanged.
- R7: With dest=0 the result is loaded into `wreg` at the end of the fourth phase and memory is not written. With dest=1, `mem_wr` is high with the result on `mem_wdata` during the fourth phase only, and `wreg` is unchanged.
- R8: An instruction word that matches neither op code still takes four busy cycles. It makes no memory read and no memory write, and it changes neither `wreg` nor `status`.
- R9: Reset clears `busy`, `wreg`, `status`, `mem_rd` and `mem_wr`. Reset asserted in the middle of an instruction aborts it with no write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin executing `instr` |
| instr | input | 16 | Instruction word |
| bank_sel | input | 4 | Bank select value for banked addressing |
| busy | output | 1 | High during the four execution phases |
| mem_addr | output | 12 | Data memory address |
| mem_rd | output | 1 | Data memory read strobe |
| mem_rdata | input | 8 | Data memory read data, valid in the same cycle |
| mem_wr | output | 1 | Data memory write strobe |
| mem_wdata | output | 8 | Data memory write data |
| wreg | output | 8 | Working register |
| status | output | 5 | Status flags {N, OV, Z, DC, C} |

## Verification
Some properties are checked on every cycle. A started instruction keeps `busy` up past its first cycle, the read and write strobes never overlap, and a file write leaves `wreg` alone. A swap keeps the flags, a non-matching word never touches memory, and the idle state holds `wreg` and `status`. Other behaviour is shown only by the bench's scenarios: the arithmetic values, flag settings such as overflow and the half-nibble borrow, the access-bank split at 0x80, bank_sel being ignored in access mode, the rejection of a start while busy, and a reset that aborts an instruction mid-flight.

// File: rtl/regalu_pkg.sv
package regalu_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEC,
    PH_RD,
    PH_EXE,
    PH_WB
  } phase_e;

  typedef enum logic [1:0] {
    OP_NOP,
    OP_SUB,
    OP_SWAP
  } op_e;

  localparam int OPC_W = 6;
  localparam logic [OPC_W-1:0] OPC_SUBB = 6'b010110;
  localparam logic [OPC_W-1:0] OPC_SWAP = 6'b001110;

  localparam int ST_C  = 0;
  localparam int ST_DC = 1;
  localparam int ST_Z  = 2;
  localparam int ST_OV = 3;
  localparam int ST_N  = 4;
  localparam int ST_W  = 5;

endpackage

// File: rtl/regalu_decode.sv
module regalu_decode
  import regalu_pkg::*;
#(
  parameter int IW = 16,
  parameter int DW = 8
) (
  input  logic [IW-1:0] instr,
  output op_e           op,
  output logic          to_file,
  output logic          banked,
  output logic [DW-1:0] faddr
);

  localparam int OPC_LSB = IW - OPC_W;

  logic [OPC_W-1:0] opc;

  always_comb begin
    opc     = instr[IW-1:OPC_LSB];
    to_file = instr[DW+1];
    banked  = instr[DW];
    faddr   = instr[DW-1:0];
    unique case (opc)
      OPC_SUBB: op = OP_SUB;
      OPC_SWAP: op = OP_SWAP;
      default:  op = OP_NOP;
    endcase
  end

endmodule

// File: rtl/regalu_addr.sv
module regalu_addr #(
  parameter int DW = 8,
  parameter int BW = 4
) (
  input  logic [DW-1:0]    faddr,
  input  logic             banked,
  input  logic [BW-1:0]    bank,
  output logic [BW+DW-1:0] addr
);

  logic [BW-1:0] acc_bank;

  always_comb begin
    acc_bank = faddr[DW-1] ? {BW{1'b1}} : {BW{1'b0}};
    addr     = {(banked ? bank : acc_bank), faddr};
  end

endmodule

// File: rtl/regalu_core.sv
module regalu_core
  import regalu_pkg::*;
#(
  parameter int DW = 8
) (
  input  op_e           op,
  input  logic [DW-1:0] opnd,
  input  logic [DW-1:0] w,
  input  logic [ST_W-1:0] st_in,
  output logic [DW-1:0] res,
  output logic [ST_W-1:0] st_out
);

  localparam int HW = DW / 2;

  logic          borrow;
  logic [DW:0]   diff;
  logic [HW:0]   low;
  logic [DW-1:0] swapped;

  always_comb begin
    borrow  = ~st_in[ST_C];
    diff    = {1'b0, opnd} - {1'b0, w} - {{DW{1'b0}}, borrow};
    low     = {1'b0, opnd[HW-1:0]} - {1'b0, w[HW-1:0]} - {{HW{1'b0}}, borrow};
    swapped = {opnd[HW-1:0], opnd[DW-1:HW]};
    res     = opnd;
    st_out  = st_in;
    unique case (op)
      OP_SUB: begin
        res           = diff[DW-1:0];
        st_out[ST_C]  = ~diff[DW];
        st_out[ST_DC] = ~low[HW];
        st_out[ST_Z]  = (diff[DW-1:0] == '0);
        st_out[ST_N]  = diff[DW-1];
        st_out[ST_OV] = (opnd[DW-1] ^ w[DW-1]) & (diff[DW-1] ^ opnd[DW-1]);
      end
      OP_SWAP: res = swapped;
      default: res = opnd;
    endcase
  end

endmodule

// File: rtl/regalu_seq.sv
module regalu_seq
  import regalu_pkg::*;
#(
  parameter int IW = 16,
  parameter int DW = 8,
  parameter int BW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IW-1:0]    instr,
  input  logic [BW-1:0]    bank_sel,
  output logic             busy,
  output logic [BW+DW-1:0] mem_addr,
  output logic             mem_rd,
  input  logic [DW-1:0]    mem_rdata,
  output logic             mem_wr,
  output logic [DW-1:0]    mem_wdata,
  output logic [DW-1:0]    wreg,
  output logic [ST_W-1:0]  status
);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rsync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  phase_e          phase_q, phase_d;
  logic [IW-1:0]   instr_q;
  logic [BW-1:0]   bank_q;
  op_e             op_q, op_dec;
  logic [DW-1:0]   opnd_q, res_q, w_q;
  logic [ST_W-1:0] flg_q, st_q;

  logic            to_file, banked;
  logic [DW-1:0]   faddr;
  logic [DW-1:0]   core_res;
  logic [ST_W-1:0] core_st;

  logic en_cap, en_op, en_opnd, en_res, en_w, en_st;

  regalu_decode #(.IW(IW), .DW(DW)) u_dec (
    .instr   (instr_q),
    .op      (op_dec),
    .to_file (to_file),
    .banked  (banked),
    .faddr   (faddr)
  );

  regalu_addr #(.DW(DW), .BW(BW)) u_addr (
    .faddr  (faddr),
    .banked (banked),
    .bank   (bank_q),
    .addr   (mem_addr)
  );

  regalu_core #(.DW(DW)) u_core (
    .op     (op_q),
    .opnd   (opnd_q),
    .w      (w_q),
    .st_in  (st_q),
    .res    (core_res),
    .st_out (core_st)
  );

  // next state and clock enables
  always_comb begin
    phase_d = phase_q;
    en_cap  = 1'b0;
    en_op   = 1'b0;
    en_opnd = 1'b0;
    en_res  = 1'b0;
    en_w    = 1'b0;
    en_st   = 1'b0;
    unique case (phase_q)
      PH_IDLE: if (start) begin
        phase_d = PH_DEC;
        en_cap  = 1'b1;
      end
      PH_DEC: begin
        phase_d = PH_RD;
        en_op   = 1'b1;
      end
      PH_RD: begin
        phase_d = PH_EXE;
        en_opnd = mem_rd;
      end
      PH_EXE: begin
        phase_d = PH_WB;
        en_res  = 1'b1;
      end
      PH_WB: begin
        phase_d = PH_IDLE;
        en_w    = (op_q != OP_NOP) && !to_file;
        en_st   = (op_q == OP_SUB);
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) phase_q <= PH_IDLE;
    else          phase_q <= phase_d;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      instr_q <= '0;
      bank_q  <= '0;
    end else if (en_cap) begin
      instr_q <= instr;
      bank_q  <= bank_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)   op_q <= OP_NOP;
    else if (en_op) op_q <= op_dec;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)     opnd_q <= '0;
    else if (en_opnd) opnd_q <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      res_q <= '0;
      flg_q <= '0;
    end else if (en_res) begin
      res_q <= core_res;
      flg_q <= core_st;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)  w_q <= '0;
    else if (en_w) w_q <= res_q;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)   st_q <= '0;
    else if (en_st) st_q <= flg_q;
  end

  assign busy      = (phase_q != PH_IDLE);
  assign mem_rd    = (phase_q == PH_RD) && (op_q != OP_NOP);
  assign mem_wr    = (phase_q == PH_WB) && (op_q != OP_NOP) && to_file;
  assign mem_wdata = res_q;
  assign wreg      = w_q;
  assign status    = st_q;

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(busy) |=> busy); // R2

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(mem_rd && mem_wr)); // R3

  AST_FILE_WR_KEEPS_W: assert property (@(posedge clk) disable iff (!rst_i_n)
    mem_wr |=> $stable(wreg)); // R7

  AST_SWAP_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_i_n)
    (phase_q == PH_WB && op_q == OP_SWAP) |=> $stable(status)); // R6

  AST_NOP_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_i_n)
    (busy && phase_q != PH_DEC && op_q == OP_NOP) |-> (!mem_rd && !mem_wr)); // R8

  AST_IDLE_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_i_n)
    !busy |=> ($stable(wreg) && $stable(status))); // R9

endmodule

// File: tb/regalu_seq_tb.sv
module regalu_seq_tb;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [15:0] instr;
  logic [3:0]  bank_sel;
  logic        busy;
  logic [11:0] mem_addr;
  logic        mem_rd;
  logic [7:0]  mem_rdata;
  logic        mem_wr;
  logic [7:0]  mem_wdata;
  logic [7:0]  wreg;
  logic [4:0]  status;

  logic [7:0] mem [4096];
  int checks = 0;
  int errors = 0;

  assign mem_rdata = mem[mem_addr];

  regalu_seq u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .instr     (instr),
    .bank_sel  (bank_sel),
    .busy      (busy),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_rdata (mem_rdata),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .wreg      (wreg),
    .status    (status)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // vector: instr, bank, preload, addr, rd, wr, wdata, wreg, status
  localparam int NV = 13;
  localparam logic [62:0] VEC [NV] = '{
    {16'h5810, 4'h7, 8'h0E, 12'h010, 1'b1, 1'b0, 8'h00, 8'h0D, 5'h03},
    {16'h5A20, 4'h0, 8'h19, 12'h020, 1'b1, 1'b1, 8'h0C, 8'h0D, 5'h01},
    {16'h5940, 4'h3, 8'h1B, 12'h340, 1'b1, 1'b0, 8'h00, 8'h0E, 5'h01},
    {16'h5A85, 4'h9, 8'h03, 12'hF85, 1'b1, 1'b1, 8'hF5, 8'h0E, 5'h10},
    {16'h3B53, 4'h5, 8'h53, 12'h553, 1'b1, 1'b1, 8'h35, 8'h0E, 5'h10},
    {16'h38FF, 4'h0, 8'hA7, 12'hFFF, 1'b1, 1'b0, 8'h00, 8'h7A, 5'h10},
    {16'h5811, 4'h0, 8'h95, 12'h011, 1'b1, 1'b0, 8'h00, 8'h1A, 5'h09},
    {16'h5A12, 4'h0, 8'h00, 12'h012, 1'b1, 1'b1, 8'hE6, 8'h1A, 5'h10},
    {16'h5813, 4'h0, 8'h1B, 12'h013, 1'b1, 1'b0, 8'h00, 8'h00, 5'h07},
    {16'h0013, 4'h0, 8'h00, 12'h000, 1'b0, 1'b0, 8'h00, 8'h00, 5'h07},
    {16'h5F13, 4'h0, 8'h00, 12'h000, 1'b0, 1'b0, 8'h00, 8'h00, 5'h07},
    {16'h5980, 4'hF, 8'h80, 12'hF80, 1'b1, 1'b0, 8'h00, 8'h80, 5'h13},
    {16'h5830, 4'h0, 8'h01, 12'h030, 1'b1, 1'b0, 8'h00, 8'h81, 5'h1A}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input int i);
    logic [15:0] v_instr;
    logic [3:0]  v_bank;
    logic [7:0]  v_pre, v_wd, v_w;
    logic [11:0] v_addr;
    logic        v_rd, v_wr;
    logic [4:0]  v_st;
    string       req;
    {v_instr, v_bank, v_pre, v_addr, v_rd, v_wr, v_wd, v_w, v_st} = VEC[i];
    if (v_instr[15:10] == 6'b010110)      req = "R4/R5";
    else if (v_instr[15:10] == 6'b001110) req = "R6";
    else                                  req = "R8";
    @(negedge clk);
    if (v_rd) mem[v_addr] = v_pre;
    instr    = v_instr;
    bank_sel = v_bank;
    start    = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2", "busy phase1", busy, 1);
    @(posedge clk); @(negedge clk);
    check(mem_rd == v_rd, v_rd ? "R3" : "R8", "read strobe", mem_rd, v_rd);
    if (v_rd) check(mem_addr == v_addr, "R3", "address", mem_addr, v_addr);
    @(posedge clk); @(negedge clk);
    check(busy == 1'b1 && mem_wr == 1'b0, "R7", "phase3 quiet", {busy, mem_wr}, 2'b10);
    @(posedge clk); @(negedge clk);
    check(mem_wr == v_wr, "R7", "write strobe", mem_wr, v_wr);
    if (v_wr) begin
      check(mem_wdata == v_wd, req, "write data", mem_wdata, v_wd);
      mem[mem_addr] = mem_wdata;
    end
    @(posedge clk); @(negedge clk);
    check(busy == 1'b0, "R2", "busy after four", busy, 0);
    check(wreg == v_w, req, "wreg", wreg, v_w);
    check(status == v_st, (req == "R6") ? "R6" : ((req == "R8") ? "R8" : "R5"),
          "status", status, v_st);
    if (v_rd && !v_wr) check(mem[v_addr] == v_pre, "R7", "file untouched", mem[v_addr], v_pre);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL R2 watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int busy_cnt;
    rst_n    = 1'b0;
    start    = 1'b0;
    instr    = '0;
    bank_sel = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    check(busy == 0 && mem_rd == 0 && mem_wr == 0, "R9", "reset strobes",
          {busy, mem_rd, mem_wr}, 0);
    check(wreg == 8'h00 && status == 5'h00, "R9", "reset regs", {wreg, 3'b0, status}, 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 R3 R4 R5 R6 R7 R8 table
    for (int i = 0; i < NV; i++) run_vec(i);

    // R2: start held while busy is ignored; swap d=0 of 0x12 gives W=0x21
    @(negedge clk);
    mem[12'h021] = 8'h12;
    instr    = 16'h3821;
    bank_sel = 4'h0;
    start    = 1'b1;
    busy_cnt = 0;
    @(posedge clk);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (busy) busy_cnt++;
      if (k == 2) start = 1'b0;
      @(posedge clk);
    end
    @(negedge clk);
    check(busy_cnt == 4, "R2", "busy cycles", busy_cnt, 4);
    check(busy == 1'b0, "R2", "restart ignored", busy, 0);
    check(wreg == 8'h21, "R6", "swap to wreg", wreg, 8'h21);
    check(status == 5'h1A, "R6", "flags kept", status, 5'h1A);

    // R9: reset in the middle of a file-write subtract aborts it
    @(negedge clk);
    mem[12'h022] = 8'h44;
    instr = 16'h5A22;
    start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(busy == 0 && mem_wr == 0, "R9", "abort strobes", {busy, mem_wr}, 0);
    check(wreg == 8'h00 && status == 5'h00, "R9", "abort regs", {wreg, 3'b0, status}, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(mem[12'h022] == 8'h44, "R9", "no write after abort", mem[12'h022], 8'h44);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(busy == 1'b0, "R9", "idle after release", busy, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule